// File: doc/BRIEF.md
# Reciprocal-Multiply Block Quantizer

This block quantizes 8x8 blocks of signed transform coefficients. Coefficients enter one per cycle in raster order, with a valid flag and a marker on the first coefficient of each block. Each one is scaled by the reciprocal of the quantization step for its position, and the scaled value is rounded to the nearest integer. The result leaves the block with its 6-bit position index. The block uses no divider. The reciprocals are fixed-point constants built when the design is elaborated, and one multiplier applies them.

A table-select input picks one of two step tables. Table 0 is the usual luminance table for moderate compression. Table 1 has every step five times larger, which gives coarser output for much stronger compression. A truncation-count input clears low bits of both multiplier operands. This trades accuracy for a cheaper product. Both settings are captured on the first coefficient of a block and held until the next block starts.

Top module: `quant_block_top`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `out_valid` is 0.
- R2: Every accepted coefficient produces exactly one output, 3 clock edges after the edge that accepts it. Outputs keep their input order. Idle input cycles produce no output.
- R3: `out_idx` is 0 for a coefficient that carries `in_sob`. Each later accepted coefficient has the index of the one before it plus 1, and index 63 is followed by 0.
- R4: With truncation 0 and table 0, the output is the coefficient divided by step Q[idx], rounded to nearest with ties away from zero. Table 0 in raster order is 16 11 10 16 24 40 51 61 / 12 12 14 19 26 58 60 55 / 14 13 16 24 40 57 69 56 / 14 17 22 29 51 87 80 62 / 18 22 37 56 68 109 103 77 / 24 35 55 64 81 104 113 92 / 49 64 78 87 103 121 120 101 / 72 92 95 98 112 100 103 99. The result is exact for every input in ±2047.
- R5: With table select 1, every step is 5 times the table-0 step at the same index, and the rounding is the one in R4.
- R6: A negative coefficient gives the negation of the result for its magnitude.
- R7: With truncation T > 0, the reciprocal is R = ceil(2^21/Q). Both the magnitude m and R have their low T bits cleared. The magnitude of the result is floor((m'·R' + 2^20) / 2^21), and the sign follows R6.
- R8: Table select and truncation are sampled only on a coefficient that carries `in_sob`. Changes to them at any other time have no effect until the next block starts.
- R9: A zero coefficient gives a zero output for every setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Coefficient present this cycle |
| in_sob | input | 1 | First coefficient of a block |
| in_coef | input | 12 | Signed coefficient |
| tbl_sel | input | 1 | Step table: 0 normal, 1 coarse |
| trunc_cnt | input | 5 | Operand low bits to clear |
| out_valid | output | 1 | Quantized value present |
| out_idx | output | 6 | Raster position of the value |
| out_level | output | 12 | Signed quantized value |

## Verification
The hardest case to reach is an exact rounding tie. It only occurs when the step is even and the coefficient is an odd multiple of half the step, and a reciprocal that is a little low would then round the wrong way. The stimulus builds whole blocks in which every position carries such a tie, in both signs and for both tables. It then sweeps a stride pattern over the full ±2047 range at all 64 positions. A separate block changes the settings in the middle of the block and runs past index 63 without a new start marker, to show that both the latched settings and the index wrap come from the start-of-block sample alone.

// File: rtl/qz_pkg.sv
package qz_pkg;

    localparam int unsigned POS_N = 64;
    localparam int unsigned IDX_W = $clog2(POS_N);

    // normal step table in raster order
    localparam int unsigned STEP_LO [POS_N] = '{
        16, 11, 10, 16, 24, 40, 51, 61,
        12, 12, 14, 19, 26, 58, 60, 55,
        14, 13, 16, 24, 40, 57, 69, 56,
        14, 17, 22, 29, 51, 87, 80, 62,
        18, 22, 37, 56, 68, 109, 103, 77,
        24, 35, 55, 64, 81, 104, 113, 92,
        49, 64, 78, 87, 103, 121, 120, 101,
        72, 92, 95, 98, 112, 100, 103, 99
    };

    localparam int unsigned COARSE_MUL = 5;

    // ceil(2^frac / q), evaluated at elaboration
    function automatic longint unsigned recip_of(input int unsigned frac, input int unsigned q);
        longint unsigned one;
        one = longint'(1) << frac;
        return (one + longint'(q) - 1) / longint'(q);
    endfunction

endpackage

// File: rtl/qz_pos_seq.sv
module qz_pos_seq #(
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned TRUNC_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_sob,
    input  logic               tbl_sel,
    input  logic [TRUNC_W-1:0] trunc_cnt,
    output logic [IDX_W-1:0]   eff_idx,
    output logic               eff_sel,
    output logic [TRUNC_W-1:0] eff_trunc
);
    logic [IDX_W-1:0]   next_idx;
    logic               sel_q;
    logic [TRUNC_W-1:0] trunc_q;

    always_comb begin
        eff_idx   = in_sob ? '0 : next_idx;
        eff_sel   = in_sob ? tbl_sel : sel_q;
        eff_trunc = in_sob ? trunc_cnt : trunc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_idx <= '0;
            sel_q    <= 1'b0;
            trunc_q  <= '0;
        end else if (in_valid) begin
            next_idx <= eff_idx + 1'b1;
            if (in_sob) begin
                sel_q   <= tbl_sel;
                trunc_q <= trunc_cnt;
            end
        end
    end
endmodule

// File: rtl/qz_recip_rom.sv
module qz_recip_rom #(
    parameter int unsigned FRAC_W  = 21,
    parameter int unsigned RECIP_W = 19
) (
    input  logic [qz_pkg::IDX_W-1:0] idx,
    input  logic                     sel,
    output logic [RECIP_W-1:0]       recip
);
    import qz_pkg::*;

    logic [RECIP_W-1:0] rom_lo [POS_N];
    logic [RECIP_W-1:0] rom_hi [POS_N];

    for (genvar g = 0; g < int'(POS_N); g++) begin : g_entry
        localparam int unsigned QL = STEP_LO[g];
        localparam int unsigned QH = STEP_LO[g] * COARSE_MUL;
        assign rom_lo[g] = RECIP_W'(recip_of(FRAC_W, QL));
        assign rom_hi[g] = RECIP_W'(recip_of(FRAC_W, QH));
    end

    assign recip = sel ? rom_hi[idx] : rom_lo[idx];
endmodule

// File: rtl/qz_approx_mul.sv
module qz_approx_mul #(
    parameter int unsigned A_W     = 12,
    parameter int unsigned B_W     = 19,
    parameter int unsigned TRUNC_W = 5
) (
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    input  logic [TRUNC_W-1:0] trunc,
    output logic [A_W+B_W-1:0] prod
);
    logic [A_W-1:0] a_cut;
    logic [B_W-1:0] b_cut;

    always_comb begin
        a_cut = a & ({A_W{1'b1}} << trunc);
        b_cut = b & ({B_W{1'b1}} << trunc);
        prod  = (A_W+B_W)'(a_cut) * (A_W+B_W)'(b_cut);
    end
endmodule

// File: rtl/quant_block_top.sv
module quant_block_top #(
    parameter int unsigned COEF_W  = 12,
    parameter int unsigned FRAC_W  = 21,
    parameter int unsigned TRUNC_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_sob,
    input  logic signed [COEF_W-1:0] in_coef,
    input  logic                     tbl_sel,
    input  logic [TRUNC_W-1:0]       trunc_cnt,
    output logic                     out_valid,
    output logic [qz_pkg::IDX_W-1:0] out_idx,
    output logic signed [COEF_W-1:0] out_level
);
    import qz_pkg::*;

    localparam int unsigned RECIP_W = FRAC_W - 2;
    localparam int unsigned PROD_W  = COEF_W + RECIP_W;

    typedef struct packed {
        logic               vld;
        logic [IDX_W-1:0]   idx;
        logic               neg;
        logic [COEF_W-1:0]  mag;
        logic [RECIP_W-1:0] recip;
        logic [TRUNC_W-1:0] trunc;
    } s1_t;

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic              neg;
        logic [PROD_W-1:0] prod;
    } s2_t;

    logic [IDX_W-1:0]   eff_idx;
    logic               eff_sel;
    logic [TRUNC_W-1:0] eff_trunc;
    logic [RECIP_W-1:0] rom_recip;
    logic [PROD_W-1:0]  mul_prod;
    logic [PROD_W-1:0]  rounded;
    logic [COEF_W-1:0]  abs_coef;
    s1_t                s1;
    s2_t                s2;

    qz_pos_seq #(.IDX_W(IDX_W), .TRUNC_W(TRUNC_W)) i_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sob(in_sob),
        .tbl_sel(tbl_sel), .trunc_cnt(trunc_cnt),
        .eff_idx(eff_idx), .eff_sel(eff_sel), .eff_trunc(eff_trunc)
    );

    qz_recip_rom #(.FRAC_W(FRAC_W), .RECIP_W(RECIP_W)) i_rom (
        .idx(eff_idx), .sel(eff_sel), .recip(rom_recip)
    );

    qz_approx_mul #(.A_W(COEF_W), .B_W(RECIP_W), .TRUNC_W(TRUNC_W)) i_mul (
        .a(s1.mag), .b(s1.recip), .trunc(s1.trunc), .prod(mul_prod)
    );

    assign abs_coef = in_coef[COEF_W-1] ? COEF_W'(-in_coef) : COEF_W'(in_coef);
    assign rounded  = (mul_prod + (PROD_W'(1) << (FRAC_W-1))) >> FRAC_W;

    // stage 1: position, settings, magnitude, reciprocal
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld   <= in_valid;
            s1.idx   <= eff_idx;
            s1.neg   <= in_coef[COEF_W-1];
            s1.mag   <= abs_coef;
            s1.recip <= rom_recip;
            s1.trunc <= eff_trunc;
        end
    end

    // stage 2: rounded magnitude of the scaled product
    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.vld  <= s1.vld;
            s2.idx  <= s1.idx;
            s2.neg  <= s1.neg;
            s2.prod <= rounded;
        end
    end

    // stage 3: sign restore
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_level <= '0;
        end else begin
            out_valid <= s2.vld;
            out_idx   <= s2.idx;
            out_level <= s2.neg ? -COEF_W'(s2.prod) : COEF_W'(s2.prod);
        end
    end
endmodule

// File: rtl/quant_block_chk.sv
module quant_block_chk #(
    parameter int unsigned COEF_W  = 12,
    parameter int unsigned TRUNC_W = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     in_sob,
    input logic signed [COEF_W-1:0] in_coef,
    input logic                     out_valid,
    input logic [5:0]               out_idx,
    input logic signed [COEF_W-1:0] out_level
);
    // R2
    lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);
    // R2
    lat_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid);
    // R3
    sob_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sob) |-> ##3 (out_idx == 6'd0));
    // R9
    zero_in_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_coef == '0) |-> ##3 (out_level == '0));
    // R6
    pos_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_coef > 0) |-> ##3 (out_level >= 0));
    // R6
    neg_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_coef < 0) |-> ##3 (out_level <= 0));
    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind quant_block_top quant_block_chk #(.COEF_W(COEF_W), .TRUNC_W(TRUNC_W)) i_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sob(in_sob), .in_coef(in_coef),
    .out_valid(out_valid), .out_idx(out_idx), .out_level(out_level)
);

// File: tb/test_quant_block_top.sv
module test_quant_block_top;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_sob = 1'b0;
    logic signed [11:0] in_coef = '0;
    logic              tbl_sel = 1'b0;
    logic [4:0]        trunc_cnt = '0;
    logic              out_valid;
    logic [5:0]        out_idx;
    logic signed [11:0] out_level;

    always #4 clk = ~clk;

    quant_block_top i_quant_block_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sob(in_sob), .in_coef(in_coef),
        .tbl_sel(tbl_sel), .trunc_cnt(trunc_cnt),
        .out_valid(out_valid), .out_idx(out_idx), .out_level(out_level)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int n_sent = 0;
    int n_got = 0;
    int exp_lvl [16384];
    int exp_idx [16384];
    int sent_at [16384];
    string exp_tag [16384];
    int b_sel = 0;
    int b_tr = 0;
    int b_idx = 0;

    int qtab [64] = '{
        16, 11, 10, 16, 24, 40, 51, 61,
        12, 12, 14, 19, 26, 58, 60, 55,
        14, 13, 16, 24, 40, 57, 69, 56,
        14, 17, 22, 29, 51, 87, 80, 62,
        18, 22, 37, 56, 68, 109, 103, 77,
        24, 35, 55, 64, 81, 104, 113, 92,
        49, 64, 78, 87, 103, 121, 120, 101,
        72, 92, 95, 98, 112, 100, 103, 99
    };

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int step_of(input int sel, input int idx);
        return (sel != 0) ? 5 * qtab[idx] : qtab[idx];   // R5
    endfunction

    function automatic int expect_q(input int x, input int q, input int t);
        longint m, r, mask, v;
        m = (x < 0) ? -x : x;
        if (t == 0) begin
            v = (2 * m + q) / (2 * q);                   // R4 exact, ties away
        end else begin
            r = ((longint'(1) << 21) + q - 1) / q;       // R7
            mask = ~((longint'(1) << t) - 1);
            v = (((m & mask) * (r & mask)) + (longint'(1) << 20)) >> 21;
        end
        return (x < 0) ? -int'(v) : int'(v);             // R6
    endfunction

    task automatic check(input string tag, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic beat(input int x, input bit sob, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_sob = sob;
        in_coef = 12'(x);
        if (sob) begin
            b_sel = int'(tbl_sel);
            b_tr = int'(trunc_cnt);
            b_idx = 0;
        end
        exp_idx[n_sent] = b_idx;
        exp_lvl[n_sent] = expect_q(x, step_of(b_sel, b_idx), b_tr);
        exp_tag[n_sent] = tag;
        sent_at[n_sent] = cyc;
        n_sent++;
        b_idx = (b_idx + 1) % 64;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sob = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (n_got >= n_sent) begin
                check("R2 extra output", 1, 0);
            end else begin
                check({exp_tag[n_got], " level"}, int'(out_level), exp_lvl[n_got]);
                check("R3 index", int'(out_idx), exp_idx[n_got]);
                check("R2 latency", cyc - sent_at[n_got], 3);
            end
            n_got++;
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset valid", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset valid", int'(out_valid), 0);

        // R4 / R5: stride sweep across the whole input range, all positions
        for (int s = 0; s < 2; s++) begin
            tbl_sel = 1'(s);
            trunc_cnt = '0;
            for (int b = 0; b < 64; b++) begin
                for (int p = 0; p < 64; p++) begin
                    beat(-2047 + (((b * 64 + p) * 997) % 4095), p == 0, s == 0 ? "R4" : "R5");
                    if (p % 17 == 16) idle(1);           // R2 gaps
                end
            end
        end

        // R6: exact ties in both signs, both tables
        for (int s = 0; s < 2; s++) begin
            for (int sg = 0; sg < 2; sg++) begin
                tbl_sel = 1'(s);
                trunc_cnt = '0;
                for (int p = 0; p < 64; p++) begin
                    int q;
                    int k;
                    q = step_of(s, p);
                    k = (s == 0) ? 3 : 0;
                    beat((sg == 0 ? 1 : -1) * (q * k + q / 2 + (q % 2)), p == 0, "R6");
                end
            end
        end

        // R7: truncated operands
        for (int t = 1; t <= 12; t++) begin
            tbl_sel = 1'(t % 2);
            trunc_cnt = 5'(t);
            for (int p = 0; p < 64; p++)
                beat(-2047 + ((p * 331 + t * 71) % 4095), p == 0, "R7");
        end

        // R8: settings change in the middle of a block are ignored
        tbl_sel = 1'b0;
        trunc_cnt = '0;
        for (int p = 0; p < 64; p++) begin
            if (p == 5) begin
                tbl_sel = 1'b1;
                trunc_cnt = 5'd9;
            end
            beat(1500 - p * 37, p == 0, "R8");
        end

        // R3 wrap: run past 63 with no new start marker
        tbl_sel = 1'b0;
        trunc_cnt = '0;
        for (int p = 0; p < 70; p++)
            beat(900 - p * 11, p == 0, "R3");

        // R9: zero input under coarse table and truncation
        tbl_sel = 1'b1;
        trunc_cnt = 5'd4;
        for (int p = 0; p < 64; p++)
            beat(0, p == 0, "R9");

        idle(8);
        check("R2 output count", n_got, n_sent);
        finish_run();
    end
endmodule